// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This unit sits between a 32-bit processor datapath and a data memory that is organised as whole words. For each access it adds a sign-extended 16-bit displacement to a base register value to form a byte address. It presents the word-aligned address to the memory. For stores it places the data on the correct byte lane and drives per-lane write strobes. For loads it picks the addressed byte out of the returned word and zero-extends it, or it passes a whole word through.

Byte numbering inside a word follows a configuration input, or a parameter can fix it. In big-endian numbering, byte offset 0 is the most significant byte of the word. In little-endian numbering, byte offset 0 is the least significant byte. A byte store touches only one lane, so the memory keeps the other three bytes of the word. A word access that is not on a 4-byte boundary is flagged, and the unit neither writes nor reads memory for it.

A request is captured on a clock edge, and the memory-side outputs are driven from registers during the following cycle. The load result is formed combinationally from the memory read word in that same cycle.

Top module: `byte_lane_lsu`

## Requirements
- R1: One cycle after a valid access request, mem_addr equals base plus the sign-extended offset, computed modulo 2^32, with bits 1:0 forced to 00.
- R2: An aligned word store (req_op 3'b011) drives mem_wstrb = 4'b1111 and mem_wdata = store_data in the following cycle.
- R3: A byte store (req_op 3'b100) drives exactly one mem_wstrb bit, and that lane of mem_wdata carries store_data[7:0]. The other three bytes of the addressed memory word keep their previous values.
- R4: Lane index L selects strobe bit L and data bits 8L+7:8L. With big_endian = 0, L equals address bits 1:0. With big_endian = 1, L equals 3 minus address bits 1:0.
- R5: For a byte load (req_op 3'b010), mem_rd_en is 1 in the following cycle. In that cycle load_data[7:0] is the selected lane of mem_rdata and load_data[31:8] is zero, both formed combinationally from mem_rdata.
- R6: For an aligned word load (req_op 3'b001), mem_rd_en is 1 in the following cycle and load_data equals mem_rdata unchanged in either byte numbering.
- R7: A word load or store whose address bits 1:0 are not 00 sets mem_misalign in the following cycle, with mem_wstrb = 0 and mem_rd_en = 0, and the memory is left unchanged. A byte access never sets mem_misalign.
- R8: While rst_n is low, mem_wstrb, mem_rd_en, mem_misalign, mem_addr, mem_wdata and load_data are all zero.
- R9: When req_valid is 0, or req_op is 3'b000 or any code above 3'b100, the following cycle has mem_wstrb = 0, mem_rd_en = 0, mem_misalign = 0 and load_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present this cycle |
| req_op | input | 3 | Access kind: 001 word load, 010 byte load, 011 word store, 100 byte store |
| big_endian | input | 1 | 1 selects big-endian byte numbering, 0 selects little-endian |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data with the byte placed on its lane |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_rd_en | output | 1 | Memory read this cycle; load_data valid |
| mem_misalign | output | 1 | Misaligned word access was rejected |
| mem_rdata | input | 32 | Word returned by the memory |
| load_data | output | 32 | Extended load result |

## Verification
A wrong lane index shows up as a strobe bit in the mirrored position or as the wrong byte on load_data. With big-endian numbering the mirrored lane is the tell, and the bench separates the two numberings by using odd offsets, so the fault is visible in the very next cycle. A stale captured lane or opcode corrupts only the cycle after the request, and back-to-back stores followed by word read-backs expose it. Read-backs also catch a strobe that writes more lanes than one, by disturbing neighbouring bytes. A misalignment flag that fails to gate the strobes leaves a changed word, and a later aligned load reports it.

// File: rtl/blsu_pkg.sv
package blsu_pkg;

   typedef enum logic [2:0] {
      ACC_NONE = 3'b000,
      ACC_LDW  = 3'b001,
      ACC_LDB  = 3'b010,
      ACC_STW  = 3'b011,
      ACC_STB  = 3'b100
   } acc_op_e;

   // byte numbering source
   localparam int ENDIAN_FROM_PORT = 0;
   localparam int ENDIAN_FIX_BIG   = 1;
   localparam int ENDIAN_FIX_LITTLE = 2;

   typedef struct packed {
      logic ld_word;
      logic ld_byte;
      logic st_word;
      logic st_byte;
   } acc_dec_t;

   function automatic acc_dec_t decode_op(input logic valid, input logic [2:0] code);
      acc_dec_t d;
      d.ld_word = valid && (code == ACC_LDW);
      d.ld_byte = valid && (code == ACC_LDB);
      d.st_word = valid && (code == ACC_STW);
      d.st_byte = valid && (code == ACC_STB);
      return d;
   endfunction

endpackage

// File: rtl/blsu_addr_gen.sv
module blsu_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  offset,
   output logic [ADDR_W-1:0] eff_addr
);
   localparam int EXT_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] ofs_ext;

   generate
      if (EXT_W > 0) begin : g_extend
         assign ofs_ext = {{EXT_W{offset[OFS_W-1]}}, offset};
      end else begin : g_full
         assign ofs_ext = offset;
      end
   endgenerate

   assign eff_addr = base + ofs_ext;
endmodule

// File: rtl/blsu_lane_sel.sv
module blsu_lane_sel #(
   parameter int LANES      = 4,
   parameter int ENDIAN_SEL = 0,
   localparam int LB        = $clog2(LANES)
) (
   input  logic [LB-1:0]    byte_ofs,
   input  logic             big_endian,
   output logic [LB-1:0]    lane,
   output logic [LANES-1:0] lane_oh
);
   localparam logic [LB-1:0] TOP_LANE = LB'(LANES - 1);

   logic use_big;

   generate
      if (ENDIAN_SEL == blsu_pkg::ENDIAN_FIX_BIG) begin : g_big
         logic unused_be;
         assign unused_be = big_endian;
         assign use_big   = 1'b1;
      end else if (ENDIAN_SEL == blsu_pkg::ENDIAN_FIX_LITTLE) begin : g_little
         logic unused_be;
         assign unused_be = big_endian;
         assign use_big   = 1'b0;
      end else begin : g_port
         assign use_big = big_endian;
      end
   endgenerate

   assign lane = use_big ? (TOP_LANE - byte_ofs) : byte_ofs;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_oh
         assign lane_oh[i] = (lane == LB'(i));
      end
   endgenerate
endmodule

// File: rtl/blsu_store_pack.sv
module blsu_store_pack #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int DW    = LANES * BYTE_W
) (
   input  logic             is_byte,
   input  logic [DW-1:0]    store_data,
   input  logic [LANES-1:0] lane_oh,
   output logic [DW-1:0]    wdata,
   output logic [LANES-1:0] wstrb
);
   logic [DW-1:0] spread;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_spread
         assign spread[i*BYTE_W +: BYTE_W] = store_data[BYTE_W-1:0];
      end
   endgenerate

   always_comb begin
      if (is_byte) begin
         wdata = spread;
         wstrb = lane_oh;
      end else begin
         wdata = store_data;
         wstrb = '1;
      end
   end
endmodule

// File: rtl/blsu_load_extract.sv
module blsu_load_extract #(
   parameter int LANES  = 4,
   parameter int BYTE_W = 8,
   localparam int DW    = LANES * BYTE_W,
   localparam int LB    = $clog2(LANES)
) (
   input  logic          active,
   input  logic          is_byte,
   input  logic [LB-1:0] lane,
   input  logic [DW-1:0] rdata,
   output logic [DW-1:0] result
);
   logic [BYTE_W-1:0] byte_at [LANES];
   logic [BYTE_W-1:0] picked;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_split
         assign byte_at[i] = rdata[i*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign picked = byte_at[lane];

   always_comb begin
      if (!active)
         result = '0;
      else if (is_byte)
         result = {{(DW-BYTE_W){1'b0}}, picked};
      else
         result = rdata;
   end
endmodule

// File: rtl/byte_lane_lsu.sv
module byte_lane_lsu #(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int OFS_W      = 16,
   parameter int ENDIAN_SEL = blsu_pkg::ENDIAN_FROM_PORT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic              big_endian,
   input  logic [DATA_W-1:0] base,
   input  logic [OFS_W-1:0]  offset,
   input  logic [DATA_W-1:0] store_data,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W/BYTE_W-1:0] mem_wstrb,
   output logic              mem_rd_en,
   output logic              mem_misalign,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] load_data
);
   import blsu_pkg::*;

   localparam int LANES = DATA_W / BYTE_W;
   localparam int LB    = $clog2(LANES);

   // elaboration-time parameter checks
   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_split
         $error("DATA_W must be a multiple of BYTE_W");
      end
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("lane count must be a power of two, at least 2");
      end
      if (OFS_W < 1 || OFS_W > DATA_W) begin : g_bad_ofs
         $error("OFS_W must lie in 1..DATA_W");
      end
      if (ENDIAN_SEL < 0 || ENDIAN_SEL > 2) begin : g_bad_endian
         $error("ENDIAN_SEL must be 0, 1 or 2");
      end
   endgenerate

   logic [DATA_W-1:0] eff_addr;
   logic [LB-1:0]     byte_ofs;
   logic [LB-1:0]     lane;
   logic [LANES-1:0]  lane_oh;
   logic [DATA_W-1:0] pk_wdata;
   logic [LANES-1:0]  pk_wstrb;
   acc_dec_t          dec;
   logic              word_acc;
   logic              off_grid;
   logic              any_acc;
   logic              do_store;
   logic              do_load;

   blsu_addr_gen #(.ADDR_W(DATA_W), .OFS_W(OFS_W)) i_agen (
      .base     (base),
      .offset   (offset),
      .eff_addr (eff_addr)
   );

   assign byte_ofs = eff_addr[LB-1:0];

   blsu_lane_sel #(.LANES(LANES), .ENDIAN_SEL(ENDIAN_SEL)) i_lane (
      .byte_ofs   (byte_ofs),
      .big_endian (big_endian),
      .lane       (lane),
      .lane_oh    (lane_oh)
   );

   always_comb begin
      dec      = decode_op(req_valid, req_op);
      word_acc = dec.ld_word | dec.st_word;
      off_grid = word_acc && (byte_ofs != '0);
      any_acc  = word_acc | dec.ld_byte | dec.st_byte;
      do_store = (dec.st_word | dec.st_byte) && !off_grid;
      do_load  = (dec.ld_word | dec.ld_byte) && !off_grid;
   end

   blsu_store_pack #(.LANES(LANES), .BYTE_W(BYTE_W)) i_pack (
      .is_byte    (dec.st_byte),
      .store_data (store_data),
      .lane_oh    (lane_oh),
      .wdata      (pk_wdata),
      .wstrb      (pk_wstrb)
   );

   // request register: memory-side outputs for the following cycle
   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  wstrb_q;
   logic              rd_q;
   logic              mis_q;
   logic              ld_byte_q;
   logic [LB-1:0]     lane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q    <= '0;
         wdata_q   <= '0;
         wstrb_q   <= '0;
         rd_q      <= 1'b0;
         mis_q     <= 1'b0;
         ld_byte_q <= 1'b0;
         lane_q    <= '0;
      end else begin
         if (any_acc) begin
            addr_q    <= {eff_addr[DATA_W-1:LB], {LB{1'b0}}};
            wdata_q   <= pk_wdata;
            ld_byte_q <= dec.ld_byte;
            lane_q    <= lane;
         end
         wstrb_q <= do_store ? pk_wstrb : '0;
         rd_q    <= do_load;
         mis_q   <= off_grid;
      end
   end

   assign mem_addr     = addr_q;
   assign mem_wdata    = wdata_q;
   assign mem_wstrb    = wstrb_q;
   assign mem_rd_en    = rd_q;
   assign mem_misalign = mis_q;

   blsu_load_extract #(.LANES(LANES), .BYTE_W(BYTE_W)) i_extract (
      .active  (rd_q),
      .is_byte (ld_byte_q),
      .lane    (lane_q),
      .rdata   (mem_rdata),
      .result  (load_data)
   );
endmodule

// File: rtl/blsu_checker.sv
module blsu_checker #(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int OFS_W      = 16,
   parameter int ENDIAN_SEL = 0,
   localparam int LANES     = DATA_W / BYTE_W,
   localparam int LB        = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic              big_endian,
   input logic [DATA_W-1:0] base,
   input logic [OFS_W-1:0]  offset,
   input logic [DATA_W-1:0] store_data,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [LANES-1:0]  mem_wstrb,
   input logic              mem_rd_en,
   input logic              mem_misalign,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] load_data
);
   logic [DATA_W-1:0] ea_ref;
   logic [DATA_W-1:0] ea_word;
   logic [LB-1:0]     lane_ref;
   logic [LANES-1:0]  oh_ref;
   logic              be_eff;
   logic              is_access;
   logic              is_word;

   always_comb begin
      ea_ref  = base + DATA_W'(signed'(offset));
      ea_word = ea_ref & ~DATA_W'(LANES - 1);
      if (ENDIAN_SEL == 1)      be_eff = 1'b1;
      else if (ENDIAN_SEL == 2) be_eff = 1'b0;
      else                      be_eff = big_endian;
      lane_ref  = be_eff ? LB'(LANES - 1 - int'(ea_ref[LB-1:0])) : ea_ref[LB-1:0];
      oh_ref    = LANES'(1) << lane_ref;
      is_access = req_valid && (req_op >= 3'd1) && (req_op <= 3'd4);
      is_word   = req_valid && (req_op == 3'd1 || req_op == 3'd3);
   end

   // R1
   a_r1_word_address: assert property (@(posedge clk) disable iff (!rst_n)
      is_access |=> mem_addr == $past(ea_word));

   // R2
   a_r2_word_store: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd3 && ea_ref[LB-1:0] == '0)
      |=> (mem_wstrb == '1) && (mem_wdata == $past(store_data)));

   // R3
   a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd4) |=> $countones(mem_wstrb) == 1);

   // R4
   a_r4_lane_choice: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd4) |=> mem_wstrb == $past(oh_ref));

   // R5
   a_r5_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2)
      |=> mem_rd_en && (load_data[DATA_W-1:BYTE_W] == '0));

   // R6
   a_r6_word_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd1 && ea_ref[LB-1:0] == '0)
      |=> mem_rd_en && (load_data == mem_rdata));

   // R7
   a_r7_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (is_word && ea_ref[LB-1:0] != '0) |=> mem_misalign);

   // R7
   a_r7_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      mem_misalign |-> (mem_wstrb == '0) && !mem_rd_en);

   // R7
   a_r7_byte_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 3'd2 || req_op == 3'd4)) |=> !mem_misalign);

   // R9
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !is_access |=> (mem_wstrb == '0) && !mem_rd_en && !mem_misalign && (load_data == '0));
endmodule

bind byte_lane_lsu blsu_checker #(
   .DATA_W(DATA_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W), .ENDIAN_SEL(ENDIAN_SEL)
) i_blsu_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .big_endian   (big_endian),
   .base         (base),
   .offset       (offset),
   .store_data   (store_data),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .mem_wstrb    (mem_wstrb),
   .mem_rd_en    (mem_rd_en),
   .mem_misalign (mem_misalign),
   .mem_rdata    (mem_rdata),
   .load_data    (load_data)
);

// File: tb/test_byte_lane_lsu.sv
`timescale 1ns/1ps
module test_byte_lane_lsu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'b000;
   logic        big_endian = 1'b0;
   logic [31:0] base = '0;
   logic [15:0] offset = '0;
   logic [31:0] store_data = '0;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_wstrb;
   logic        mem_rd_en;
   logic        mem_misalign;
   logic [31:0] mem_rdata;
   logic [31:0] load_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   byte_lane_lsu i_byte_lane_lsu (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_op       (req_op),
      .big_endian   (big_endian),
      .base         (base),
      .offset       (offset),
      .store_data   (store_data),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_wstrb    (mem_wstrb),
      .mem_rd_en    (mem_rd_en),
      .mem_misalign (mem_misalign),
      .mem_rdata    (mem_rdata),
      .load_data    (load_data)
   );

   // word-array memory model, 16 words
   logic [31:0] mem [16];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < 16; w++) mem[w] <= 32'h0;
         mem[0] <= 32'h0090_12A0;
         mem[1] <= 32'hFFFF_FFFF;
         mem[2] <= 32'h1122_3344;
         mem[3] <= 32'hCAFE_F00D;
      end else begin
         for (int b = 0; b < 4; b++)
            if (mem_wstrb[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end
   end

   assign mem_rdata = mem[mem_addr[5:2]];

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic        be;
      logic [31:0] bs;
      logic [15:0] ofs;
      logic [31:0] sd;
      logic [31:0] e_addr;
      logic [3:0]  e_strb;
      logic        e_mis;
      logic        e_rd;
      logic [31:0] e_ld;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{4'd6, 3'b001, 1'b0, 32'h8,        16'h0000, 32'h0,        32'h8,        4'h0, 1'b0, 1'b1, 32'h1122_3344}, // R6
      '{4'd5, 3'b010, 1'b0, 32'h8,        16'h0001, 32'h0,        32'h8,        4'h0, 1'b0, 1'b1, 32'h0000_0033}, // R5 R4
      '{4'd4, 3'b010, 1'b1, 32'h8,        16'h0001, 32'h0,        32'h8,        4'h0, 1'b0, 1'b1, 32'h0000_0022}, // R4
      '{4'd1, 3'b010, 1'b0, 32'h10,       16'hFFFB, 32'h0,        32'h8,        4'h0, 1'b0, 1'b1, 32'h0000_0011}, // R1 negative offset
      '{4'd4, 3'b010, 1'b1, 32'h10,       16'hFFFB, 32'h0,        32'h8,        4'h0, 1'b0, 1'b1, 32'h0000_0044}, // R4
      '{4'd7, 3'b001, 1'b0, 32'hC,        16'h0002, 32'h0,        32'hC,        4'h0, 1'b1, 1'b0, 32'h0},         // R7 load
      '{4'd7, 3'b011, 1'b0, 32'h0,        16'h0001, 32'h1234_5678,32'h0,        4'h0, 1'b1, 1'b0, 32'h0},         // R7 store
      '{4'd5, 3'b010, 1'b1, 32'hC,        16'h0003, 32'h0,        32'hC,        4'h0, 1'b0, 1'b1, 32'h0000_000D}, // R5
      '{4'd3, 3'b100, 1'b0, 32'h20,       16'hFFF6, 32'hDEAD_BEAB,32'h14,       4'h4, 1'b0, 1'b0, 32'h0},         // R3 LE lane 2
      '{4'd3, 3'b100, 1'b1, 32'h14,       16'h0003, 32'h0000_00CD,32'h14,       4'h1, 1'b0, 1'b0, 32'h0},         // R3 BE lane 0
      '{4'd2, 3'b011, 1'b1, 32'h18,       16'h0000, 32'h7654_3210,32'h18,       4'hF, 1'b0, 1'b0, 32'h0},         // R2
      '{4'd3, 3'b001, 1'b0, 32'h14,       16'h0000, 32'h0,        32'h14,       4'h0, 1'b0, 1'b1, 32'h00AB_00CD}, // R3 read-back
      '{4'd2, 3'b001, 1'b1, 32'h18,       16'h0000, 32'h0,        32'h18,       4'h0, 1'b0, 1'b1, 32'h7654_3210}, // R2 read-back
      '{4'd1, 3'b001, 1'b0, 32'hFFFF_FFFC,16'h0008, 32'h0,        32'h4,        4'h0, 1'b0, 1'b1, 32'hFFFF_FFFF}, // R1 wrap
      '{4'd1, 3'b010, 1'b0, 32'h4,        16'h8000, 32'h0,        32'hFFFF_8004,4'h0, 1'b0, 1'b1, 32'h0000_00FF}, // R1 most negative
      '{4'd9, 3'b000, 1'b0, 32'h0,        16'h0000, 32'hFFFF_FFFF,32'h0,        4'h0, 1'b0, 1'b0, 32'h0},         // R9 op 000
      '{4'd9, 3'b111, 1'b0, 32'h0,        16'h0000, 32'hFFFF_FFFF,32'h0,        4'h0, 1'b0, 1'b0, 32'h0},         // R9 op 111
      '{4'd7, 3'b010, 1'b1, 32'h0,        16'h0002, 32'h0,        32'h0,        4'h0, 1'b0, 1'b1, 32'h0000_0012}  // R7 word 0 untouched
   };

   task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // call at a falling edge; returns at the falling edge where outputs are valid
   task automatic issue(input logic [2:0] op, input logic be, input logic [31:0] b,
                        input logic [15:0] o, input logic [31:0] sd);
      req_op     = op;
      big_endian = be;
      base       = b;
      offset     = o;
      store_data = sd;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   logic [31:0] got;

   initial begin
      repeat (3) @(negedge clk);
      // R8: state held under reset, even with a request present
      req_valid = 1'b1; req_op = 3'b011; base = 32'h4; store_data = 32'hAAAA_AAAA;
      @(negedge clk);
      check("R8", "wstrb", {28'h0, mem_wstrb}, 32'h0);
      check("R8", "rd_en", {31'h0, mem_rd_en}, 32'h0);
      check("R8", "misalign", {31'h0, mem_misalign}, 32'h0);
      check("R8", "addr", mem_addr, 32'h0);
      check("R8", "wdata", mem_wdata, 32'h0);
      check("R8", "load_data", load_data, 32'h0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d row %0d", VECS[i].req, i);
         issue(VECS[i].op, VECS[i].be, VECS[i].bs, VECS[i].ofs, VECS[i].sd);
         if (VECS[i].op != 3'b000 && VECS[i].op <= 3'b100)
            check(tag, "addr", mem_addr, VECS[i].e_addr);
         check(tag, "wstrb", {28'h0, mem_wstrb}, {28'h0, VECS[i].e_strb});
         check(tag, "misalign", {31'h0, mem_misalign}, {31'h0, VECS[i].e_mis});
         check(tag, "rd_en", {31'h0, mem_rd_en}, {31'h0, VECS[i].e_rd});
         check(tag, "load_data", load_data, VECS[i].e_ld);
         if (VECS[i].e_strb == 4'h4)
            check(tag, "lane byte", {24'h0, mem_wdata[23:16]}, 32'h0000_00AB);
         if (VECS[i].e_strb == 4'h1)
            check(tag, "lane byte", {24'h0, mem_wdata[7:0]}, 32'h0000_00CD);
         if (VECS[i].e_strb == 4'hF)
            check(tag, "wdata", mem_wdata, 32'h7654_3210);
      end

      // worked example, big-endian numbering (R3 R4 R5)
      issue(3'b011, 1'b1, 32'h0, 16'h0004, 32'hFFFF_FFFF);
      issue(3'b010, 1'b1, 32'h0, 16'h0001, 32'h0);
      got = load_data;
      check("R5", "BE byte load", got, 32'h0000_0090);
      issue(3'b100, 1'b1, 32'h0, 16'h0006, got);
      check("R4", "BE strobe", {28'h0, mem_wstrb}, 32'h2);
      issue(3'b001, 1'b1, 32'h0, 16'h0004, 32'h0);
      check("R3", "BE word after byte store", load_data, 32'hFFFF_90FF);

      // same, little-endian numbering
      issue(3'b011, 1'b0, 32'h0, 16'h0004, 32'hFFFF_FFFF);
      issue(3'b010, 1'b0, 32'h0, 16'h0001, 32'h0);
      got = load_data;
      check("R5", "LE byte load", got, 32'h0000_0012);
      issue(3'b100, 1'b0, 32'h0, 16'h0006, got);
      check("R4", "LE strobe", {28'h0, mem_wstrb}, 32'h4);
      issue(3'b001, 1'b0, 32'h0, 16'h0004, 32'h0);
      check("R3", "LE word after byte store", load_data, 32'hFF12_FFFF);
      issue(3'b001, 1'b0, 32'h0, 16'h0000, 32'h0);
      check("R3", "source word unchanged", load_data, 32'h0090_12A0);

      // R8: reset asserted mid-run clears outputs
      issue(3'b011, 1'b0, 32'h8, 16'h0000, 32'h5555_5555);
      rst_n = 1'b0;
      #1;
      check("R8", "wstrb after reset", {28'h0, mem_wstrb}, 32'h0);
      check("R8", "addr after reset", mem_addr, 32'h0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   end
endmodule